// File: doc/BRIEF.md
# Dynamic Walsh Switching Sequence Generator

This block produces two 128-step Walsh switching sequences, one per receiver channel, for the phase switching of a radio front end. Nothing is stored: every output bit is computed from a 7-bit step position and a sequency index. Only even (cosine-type) Walsh functions are used, which avoids any phase ambiguity between the even and odd families. The index comes from a 5-bit antenna identity set by a switch, so each antenna in an array gets its own pair of functions.

A 3-bit routing field decides what each channel carries. A channel can carry its own function, the other channel's function, a plain 50% square wave, or a constant low. A 2-bit rate field sets how long each step lasts. With the default divider on a 1 MHz reference, the choices are 4, 8, 16 or 32 ms. The rate field is separate from any noise-switching timing elsewhere in the system.

A frame marker is high for the whole of step 0. New identity, routing and rate values are taken in only as a frame begins, so a sequence is never cut part way through.

Top module: `walsh_seq_gen`

## Requirements
- R1: While `rst` is high, the step position is 0, `frame_mark` is 1, both channel outputs are 0, and the identity, routing and rate inputs are captured as the active configuration.
- R2: A step lasts `BASE_DIV << rate_sel` clock cycles of the active rate, so a frame lasts 128 times that.
- R3: The position advances by one after each step and wraps from 127 to 0. `frame_mark` is 1 during position 0 and 0 otherwise.
- R4: The Walsh bit for sequency s at position p is the XOR of p[6-i] over every i where bit i of the Gray code (s ^ (s>>1)) is 1. Even function Cal(m) has sequency 2m, and an output of 1 means the bit value 1.
- R5: For an active identity k, function A is Cal(k+1) and function B is Cal(k+32).
- R6: Routing 000 drives both channels low. Routing 001 gives channel 1 function A and channel 2 low. Routing 010 gives channel 1 low and channel 2 function B. Routing 011 gives channel 1 function A and channel 2 function B.
- R7: Routing 100 puts function A on both channels. Routing 101 puts function B on both channels.
- R8: Routing 110 puts the square wave (position bit 6) on channel 1 and drives channel 2 low. Routing 111 drives channel 1 low and puts the square wave on channel 2.
- R9: Changes on `ant_id`, `mode_sel` and `rate_sel` have no effect until the step from position 127 to position 0. At that step they become active.
- R10: Within one frame, a channel carrying Cal(m) changes value exactly 2m times, and the square wave changes once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (1 MHz in the intended setting) |
| rst | input | 1 | Synchronous active-high reset |
| ant_id | input | 5 | Antenna identity k from the per-antenna switch |
| mode_sel | input | 3 | Channel routing code (R6 to R8) |
| rate_sel | input | 2 | Step duration select (R2) |
| ch1_out | output | 1 | Channel 1 switching sequence |
| ch2_out | output | 1 | Channel 2 switching sequence |
| frame_mark | output | 1 | High during step 0 of every frame |

## Verification
The bench checks all eight routing codes against a behavioural model on every clock. The identity is set to 0, 5, 9 and 31, so the lowest index (Cal 1) and the highest (Cal 63) are both exercised, and a wrong offset between the two functions would show up.

Transition counts per frame are an independent check of sequency ordering. They tell a correctly ordered Walsh function apart from one in natural order or in bit-reversed order.

A routing change made in mid-frame shows whether reconfiguration is deferred to the frame boundary. Timing frames at the slowest and at an intermediate rate shows that the step length doubles with each rate code.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    localparam int ANT_W     = 5;
    localparam int POS_W     = ANT_W + 2;
    localparam int FRAME_LEN = 1 << POS_W;
    localparam int RATE_W    = 2;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [ANT_W-1:0] ant_t;

    typedef enum logic [2:0] {
        RT_OFF  = 3'b000,
        RT_CH1  = 3'b001,
        RT_CH2  = 3'b010,
        RT_BOTH = 3'b011,
        RT_DUPA = 3'b100,
        RT_DUPB = 3'b101,
        RT_SQ1  = 3'b110,
        RT_SQ2  = 3'b111
    } route_e;

    typedef struct packed {
        ant_t              ant;
        route_e            route;
        logic [RATE_W-1:0] rate;
    } cfg_t;

    // Sequency-ordered Walsh value: parity of position masked by the
    // bit-reversed Gray code of the sequency index.
    function automatic logic walsh_bit(pos_t pos, pos_t seq);
        pos_t gray;
        pos_t rev;
        gray = seq ^ (seq >> 1);
        for (int i = 0; i < POS_W; i++) begin
            rev[i] = gray[POS_W-1-i];
        end
        return ^(pos & rev);
    endfunction

    // Sequency of the even function for a channel: 2*(k+1) or 2*(k+2^ANT_W).
    function automatic pos_t cal_seq(ant_t ant, logic upper);
        pos_t m;
        m = upper ? (pos_t'(ant) + pos_t'(1 << ANT_W)) : (pos_t'(ant) + pos_t'(1));
        return m << 1;
    endfunction

endpackage

// File: rtl/wsg_bit_timer.sv
module wsg_bit_timer
    import wsg_pkg::*;
#(
    parameter int BASE_DIV = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int MAX_DIV = BASE_DIV << ((1 << RATE_W) - 1);
    localparam int CNT_W   = $clog2(MAX_DIV);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = CNT_W'((BASE_DIV << rate) - 1);
        tick = (cnt == lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wsg_frame_ctr.sv
module wsg_frame_ctr
    import wsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output pos_t pos,
    output logic wrap
);
    assign wrap = tick && (&pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (tick) begin
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/wsg_router.sv
module wsg_router
    import wsg_pkg::*;
(
    input  cfg_t cfg,
    input  pos_t pos,
    output logic ch1,
    output logic ch2
);
    logic [1:0] fn;
    logic       sq;

    for (genvar c = 0; c < 2; c++) begin : g_fn
        assign fn[c] = walsh_bit(pos, cal_seq(cfg.ant, c == 1));
    end

    assign sq = pos[POS_W-1];

    always_comb begin
        ch1 = 1'b0;
        ch2 = 1'b0;
        unique case (cfg.route)
            RT_OFF:  ;
            RT_CH1:  ch1 = fn[0];
            RT_CH2:  ch2 = fn[1];
            RT_BOTH: begin ch1 = fn[0]; ch2 = fn[1]; end
            RT_DUPA: begin ch1 = fn[0]; ch2 = fn[0]; end
            RT_DUPB: begin ch1 = fn[1]; ch2 = fn[1]; end
            RT_SQ1:  ch1 = sq;
            RT_SQ2:  ch2 = sq;
            default: ;
        endcase
    end
endmodule

// File: rtl/walsh_seq_gen.sv
module walsh_seq_gen
    import wsg_pkg::*;
#(
    parameter int BASE_DIV = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] ant_id,
    input  logic [2:0] mode_sel,
    input  logic [1:0] rate_sel,
    output logic       ch1_out,
    output logic       ch2_out,
    output logic       frame_mark
);
    cfg_t cfg_in;
    cfg_t cfg_q;
    logic tick;
    logic wrap;
    pos_t pos;

    always_comb begin
        cfg_in.ant   = ant_id;
        cfg_in.route = route_e'(mode_sel);
        cfg_in.rate  = rate_sel;
    end

    // Configuration is taken in only as a new frame starts.
    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            cfg_q <= cfg_in;
        end
    end

    wsg_bit_timer #(.BASE_DIV(BASE_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .rate (cfg_q.rate),
        .tick (tick)
    );

    wsg_frame_ctr u_frame (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .pos  (pos),
        .wrap (wrap)
    );

    wsg_router u_route (
        .cfg (cfg_q),
        .pos (pos),
        .ch1 (ch1_out),
        .ch2 (ch2_out)
    );

    assign frame_mark = (pos == '0);
endmodule

// File: rtl/walsh_seq_gen_chk.sv
module walsh_seq_gen_chk
    import wsg_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tick,
    input logic wrap,
    input pos_t pos,
    input cfg_t cfg_q,
    input logic ch1_out,
    input logic ch2_out,
    input logic frame_mark
);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pos));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pos == pos_t'($past(pos) + 1'b1)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && (pos == pos_t'(FRAME_LEN - 1))) |=> frame_mark);

    p_zero_start_r4: assert property (@(posedge clk) disable iff (rst)
        frame_mark |-> (!ch1_out && !ch2_out));

    p_off_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.route == RT_OFF) |-> (!ch1_out && !ch2_out));

    p_dup_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.route == RT_DUPA || cfg_q.route == RT_DUPB) |-> (ch1_out == ch2_out));

    p_sq1_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.route == RT_SQ1) |-> !ch2_out);

    p_sq2_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.route == RT_SQ2) |-> !ch1_out);

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cfg_q));
endmodule

bind walsh_seq_gen walsh_seq_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .wrap       (wrap),
    .pos        (pos),
    .cfg_q      (cfg_q),
    .ch1_out    (ch1_out),
    .ch2_out    (ch2_out),
    .frame_mark (frame_mark)
);

// File: tb/test_walsh_seq_gen.sv
module test_walsh_seq_gen;
    localparam int BD = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] ant_id;
    logic [2:0] mode_sel;
    logic [1:0] rate_sel;
    logic       ch1_out;
    logic       ch2_out;
    logic       frame_mark;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    int m_cnt = 0, m_pos = 0, m_ant = 0, m_mode = 0, m_rate = 0;
    bit m_ok = 1'b0;

    always #4 clk = ~clk;

    walsh_seq_gen #(.BASE_DIV(BD)) i_walsh_seq_gen (
        .clk        (clk),
        .rst        (rst),
        .ant_id     (ant_id),
        .mode_sel   (mode_sel),
        .rate_sel   (rate_sel),
        .ch1_out    (ch1_out),
        .ch2_out    (ch2_out),
        .frame_mark (frame_mark)
    );

    function automatic bit ref_walsh(int s, int t);
        int g;
        bit b;
        g = s ^ (s >> 1);
        b = 1'b0;
        for (int i = 0; i < 7; i++) begin
            if (((g >> i) & 1) == 1) b = b ^ bit'((t >> (6 - i)) & 1);
        end
        return b;
    endfunction

    task automatic exp_pair(input int mode, input int ant, input int p,
                            output bit e1, output bit e2);
        bit a, b, sq;
        a  = ref_walsh(2 * (ant + 1), p);
        b  = ref_walsh(2 * (ant + 32), p);
        sq = (p >= 64);
        case (mode)
            1: begin e1 = a;    e2 = 1'b0; end
            2: begin e1 = 1'b0; e2 = b;    end
            3: begin e1 = a;    e2 = b;    end
            4: begin e1 = a;    e2 = a;    end
            5: begin e1 = b;    e2 = b;    end
            6: begin e1 = sq;   e2 = 1'b0; end
            7: begin e1 = 1'b0; e2 = sq;   end
            default: begin e1 = 1'b0; e2 = 1'b0; end
        endcase
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: counts cycles and steps, reloads config at wrap.
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pos = 0;
            m_ant = ant_id; m_mode = mode_sel; m_rate = rate_sel;
        end else if (m_cnt == (BD << m_rate) - 1) begin
            m_cnt = 0;
            if (m_pos == 127) begin
                m_ant = ant_id; m_mode = mode_sel; m_rate = rate_sel;
            end
            m_pos = (m_pos + 1) % 128;
        end else begin
            m_cnt++;
        end
        m_ok = 1'b1;
    end

    // Per-cycle comparison against the reference (R3, R4, R6, R7, R8).
    always @(negedge clk) begin
        if (m_ok && !done) begin
            bit e1, e2;
            string tag;
            exp_pair(m_mode, m_ant, m_pos, e1, e2);
            tag = (m_mode < 4) ? "R4/R6" : ((m_mode < 6) ? "R5/R7" : "R8");
            check(ch1_out == e1, {tag, " ch1"}, ch1_out, e1);
            check(ch2_out == e2, {tag, " ch2"}, ch2_out, e2);
            check(frame_mark == (m_pos == 0), "R3 frame_mark", frame_mark, m_pos == 0);
        end
    end

    task automatic count_frame(output int c1, output int c2);
        bit p1, p2;
        int n;
        do @(negedge clk); while (frame_mark);
        do @(negedge clk); while (!frame_mark);
        n  = 128 * (BD << rate_sel);
        c1 = 0; c2 = 0;
        p1 = ch1_out; p2 = ch2_out;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (ch1_out != p1) c1++;
            if (ch2_out != p2) c2++;
            p1 = ch1_out; p2 = ch2_out;
        end
    endtask

    task automatic measure_frame(output int n);
        do @(negedge clk); while (frame_mark);
        do @(negedge clk); while (!frame_mark);
        n = 0;
        do begin @(negedge clk); n++; end while (frame_mark);
        do begin @(negedge clk); n++; end while (!frame_mark);
    endtask

    task automatic run_mode(input int mode, input int ant, input int x1, input int x2,
                            input string req);
        int c1, c2;
        mode_sel = 3'(mode);
        ant_id   = 5'(ant);
        count_frame(c1, c2);
        check(c1 == x1, {req, " R10 ch1 transitions"}, c1, x1);
        check(c2 == x2, {req, " R10 ch2 transitions"}, c2, x2);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        int n;
        bit e1, e2;
        rst = 1'b1; ant_id = 5'd0; mode_sel = 3'd3; rate_sel = 2'd0;
        repeat (3) @(negedge clk);
        check(frame_mark == 1'b1, "R1 reset frame_mark", frame_mark, 1);
        check(ch1_out == 1'b0, "R1 reset ch1", ch1_out, 0);
        check(ch2_out == 1'b0, "R1 reset ch2", ch2_out, 0);
        rst = 1'b0;

        run_mode(3, 0, 2, 64, "R5");      // Cal1 / Cal32
        run_mode(1, 5, 12, 0, "R6");      // Cal6 on ch1 only
        run_mode(2, 5, 0, 74, "R6");      // Cal37 on ch2 only

        // R9: routing and identity changed mid-frame must not take effect.
        mode_sel = 3'd3; ant_id = 5'd5;
        do @(negedge clk); while (frame_mark);
        repeat (40) @(negedge clk);
        mode_sel = 3'd0; ant_id = 5'd17;
        repeat (9) @(negedge clk);
        exp_pair(3, 5, m_pos, e1, e2);
        check(ch1_out == e1, "R9 ch1 unchanged mid-frame", ch1_out, e1);
        check(ch2_out == e2, "R9 ch2 unchanged mid-frame", ch2_out, e2);
        do @(negedge clk); while (!frame_mark);
        repeat (140) @(negedge clk);
        check(ch1_out == 1'b0, "R9 R6 ch1 off after frame start", ch1_out, 0);
        check(ch2_out == 1'b0, "R9 R6 ch2 off after frame start", ch2_out, 0);

        run_mode(4, 31, 64, 64, "R7");    // Cal32 on both
        run_mode(5, 31, 126, 126, "R7");  // Cal63 on both
        run_mode(4, 9, 20, 20, "R7");
        run_mode(5, 9, 82, 82, "R7");
        run_mode(6, 12, 1, 0, "R8");
        run_mode(7, 12, 0, 1, "R8");
        run_mode(0, 12, 0, 0, "R6");

        // R2: frame length follows the rate code.
        mode_sel = 3'd3; ant_id = 5'd2; rate_sel = 2'd3;
        measure_frame(n);
        check(n == 128 * (BD << 3), "R2 frame cycles rate 3", n, 128 * (BD << 3));
        rate_sel = 2'd1;
        measure_frame(n);
        check(n == 128 * (BD << 1), "R2 frame cycles rate 1", n, 128 * (BD << 1));
        run_mode(3, 2, 6, 68, "R2 R4");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            compared++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            summary();
            $finish;
        end
    end
endmodule